// File: doc/BRIEF.md
# Supply-Loss Recall Supervisor

This block watches two digitised supply comparator flags. One flag says the supply is under the upper switch threshold. The other says it is under the lower reset threshold. It keeps a pending-recall flag that is set at power-on reset and whenever the supply falls under the reset threshold. When the supply comes back above the switch threshold and a recall is pending, the block issues a one-cycle start pulse to the array's recall engine. It then holds a busy output for a fixed restore window, so that host accesses are kept off the array.

While the supply is under the switch threshold, a store-inhibit output tells the command detector to reject software store requests. A dip that reaches only the region between the two thresholds blocks stores but leaves no recall pending. If the supply drops under the switch threshold while a restore is running, that restore is abandoned and a complete new one runs after the supply recovers. Both flags pass through a synchroniser before the block uses them. Every output comes from a register.

Top module: `supply_recall_guard`

## Requirements
- R1: While `rst` is high, and on the first sampled cycle after it, `recall_busy` = 1, `store_inhibit` = 1 and `recall_start` = 0.
- R2: `store_inhibit` is 1 exactly when either supply flag, after synchronisation, is 1. Any change on the flags reaches it SYNC_STAGES+1 rising edges later.
- R3: When the reset-level flag is 1, a recall request is latched. `recall_busy` goes to 1 and stays at 1 however long the supply stays low.
- R4: When the supply recovers (both flags 0) with a recall pending, `recall_start` is 1 for exactly one cycle. `recall_busy` stays 1 through that cycle and the next RESTORE_CYC-1 cycles, then falls to 0.
- R5: A dip that raises only the switch-level flag sets `store_inhibit` but causes no `recall_start` pulse and no `recall_busy` on recovery.
- R6: If the switch-level flag rises during a restore window, `recall_busy` stays 1 and a full new RESTORE_CYC window starts, with a new `recall_start` pulse, once the supply recovers.
- R7: The combination reset flag = 1 with switch flag = 0 is treated as below the reset level: stores are inhibited and a recall is latched.
- R8: `recall_start` is never 1 in a cycle where `store_inhibit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| vdd_below_switch | input | 1 | Asynchronous flag: supply under the switch threshold |
| vdd_below_reset | input | 1 | Asynchronous flag: supply under the reset threshold |
| store_inhibit | output | 1 | Blocks software stores while the supply is low |
| recall_busy | output | 1 | Recall pending or restore window running; host held off |
| recall_start | output | 1 | One-cycle pulse that starts the array recall |

## Verification
Each flag change reaches the registered outputs on the third rising edge after it is driven (two synchroniser stages plus the output register). The bench therefore drives the flags on a falling edge and first samples the outputs three falling edges later, after checking that nothing changed one edge too early. The start pulse is due in that same cycle. `recall_busy` falls exactly RESTORE_CYC edges after the pulse, so the bench checks every cycle of the window, including its last cycle and the cycle after it. The dip-during-restore case is swept over every offset into the window at which the dip still lands inside it.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef enum logic [1:0] {
    LV_OK    = 2'd0,
    LV_BROWN = 2'd1,
    LV_DEAD  = 2'd2
  } lvl_e;

  // reset-level flag dominates; it implies the switch-level condition
  function automatic lvl_e classify(input logic sw, input logic rs);
    if (rs) return LV_DEAD;
    if (sw) return LV_BROWN;
    return LV_OK;
  endfunction
endpackage

// File: rtl/rcg_sync.sv
module rcg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcg_sequencer.sv
module rcg_sequencer
  import rcg_pkg::*;
#(
  parameter int RESTORE_CYC = 27500
) (
  input  logic clk,
  input  logic rst,
  input  lvl_e lvl,
  output logic inhibit_o,
  output logic busy_o,
  output logic go_o
);
  localparam int CW = (RESTORE_CYC > 1) ? $clog2(RESTORE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(RESTORE_CYC - 1);

  logic          pend_q, pend_d;
  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          go_q, go_d;
  logic          busy_q, busy_d;
  logic          inh_q, inh_d;

  always_comb begin
    pend_d = pend_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    go_d   = 1'b0;
    if (lvl == LV_DEAD) pend_d = 1'b1;
    if (lvl != LV_OK) begin
      // supply lost during a window: abandon it and ask for a fresh one
      if (run_q) begin
        run_d  = 1'b0;
        pend_d = 1'b1;
      end
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end else if (pend_q) begin
      run_d  = 1'b1;
      pend_d = 1'b0;
      cnt_d  = LAST;
      go_d   = 1'b1;
    end
    busy_d = pend_d | run_d;
    inh_d  = (lvl != LV_OK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b1;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      go_q   <= 1'b0;
      busy_q <= 1'b1;
      inh_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      go_q   <= go_d;
      busy_q <= busy_d;
      inh_q  <= inh_d;
    end
  end

  assign inhibit_o = inh_q;
  assign busy_o    = busy_q;
  assign go_o      = go_q;

  p_go_single_r4: assert property (@(posedge clk) disable iff (rst)
    go_q |=> !go_q);
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_run_busy_r4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> busy_q);
  p_dead_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (lvl == LV_DEAD) |=> busy_q);
  p_go_not_inhibited_r8: assert property (@(posedge clk) disable iff (rst)
    go_q |-> !inh_q);
  p_low_inhibits_r2: assert property (@(posedge clk) disable iff (rst)
    (lvl != LV_OK) |=> inh_q);
  p_dip_no_go_r6: assert property (@(posedge clk) disable iff (rst)
    (lvl != LV_OK) |=> !go_q);
endmodule

// File: rtl/supply_recall_guard.sv
module supply_recall_guard
  import rcg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESTORE_CYC = 27500
) (
  input  logic clk,
  input  logic rst,
  input  logic vdd_below_switch,
  input  logic vdd_below_reset,
  output logic store_inhibit,
  output logic recall_busy,
  output logic recall_start
);
  logic [1:0] flags_s;
  lvl_e       lvl;

  rcg_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({vdd_below_reset, vdd_below_switch}),
    .q   (flags_s)
  );

  assign lvl = classify(flags_s[0], flags_s[1]);

  rcg_sequencer #(.RESTORE_CYC(RESTORE_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .lvl       (lvl),
    .inhibit_o (store_inhibit),
    .busy_o    (recall_busy),
    .go_o      (recall_start)
  );

  p_reset_flag_r7: assert property (@(posedge clk) disable iff (rst)
    flags_s[1] |=> (store_inhibit && recall_busy));
endmodule

// File: tb/tb_supply_recall_guard.sv
module tb_supply_recall_guard;
  localparam int N  = 12;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw = 1'b1, rs = 1'b1;
  logic inh, busy, go;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supply_recall_guard #(.SYNC_STAGES(2), .RESTORE_CYC(N)) dut (
    .clk(clk), .rst(rst), .vdd_below_switch(sw), .vdd_below_reset(rs),
    .store_inhibit(inh), .recall_busy(busy), .recall_start(go)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic r);
    sw = s; rs = r;
  endtask

  // supply returns with a recall pending: pulse, full window, release
  task automatic recover(input string req);
    drive(0, 0);
    tick(LAT - 1);
    chk({req, " no early pulse"}, go, 1'b0);
    tick(1);
    chk({req, " start pulse"}, go, 1'b1);
    chk({req, " R8 inhibit low at pulse"}, inh, 1'b0);
    chk({req, " busy at pulse"}, busy, 1'b1);
    for (int i = 1; i < N; i++) begin
      tick(1);
      chk({req, " busy in window"}, busy, 1'b1);
      chk({req, " single pulse"}, go, 1'b0);
    end
    tick(1);
    chk({req, " busy released"}, busy, 1'b0);
  endtask

  initial begin
    tick(3);
    chk("R1 busy", busy, 1'b1);
    chk("R1 inhibit", inh, 1'b1);
    chk("R1 start", go, 1'b0);
    rst = 1'b0;
    tick(1);
    chk("R1 busy after release", busy, 1'b1);
    chk("R1 start after release", go, 1'b0);
    tick(200);
    chk("R3 request held", busy, 1'b1);
    chk("R3 no start while low", go, 1'b0);
    recover("R4 power-on");

    // R2 / R5: brown-out between the levels, several hold lengths
    for (int h = 1; h <= 6; h++) begin
      drive(1, 0);
      tick(LAT - 1);
      chk("R2 inhibit not early", inh, 1'b0);
      tick(1);
      chk("R2 inhibit set", inh, 1'b1);
      chk("R5 no busy", busy, 1'b0);
      tick(h * 3);
      drive(0, 0);
      tick(LAT - 1);
      chk("R2 inhibit still set", inh, 1'b1);
      tick(1);
      chk("R2 inhibit cleared", inh, 1'b0);
      for (int i = 0; i < N + 4; i++) begin
        tick(1);
        chk("R5 no start", go, 1'b0);
        chk("R5 no busy after", busy, 1'b0);
      end
    end

    // R3: full dip below reset level
    drive(1, 1);
    tick(LAT);
    chk("R3 busy latched", busy, 1'b1);
    chk("R2 inhibit deep", inh, 1'b1);
    recover("R4 after dip");

    // R7: reset flag alone
    drive(0, 1);
    tick(LAT);
    chk("R7 inhibit", inh, 1'b1);
    chk("R7 busy", busy, 1'b1);
    recover("R7 recovery");

    // R6: dip below switch at every offset inside the window
    for (int d = 1; d <= N - 2; d++) begin
      drive(1, 1);
      tick(LAT);
      drive(0, 0);
      tick(LAT);
      chk("R6 first pulse", go, 1'b1);
      tick(d - 1);
      drive(1, 0);
      for (int i = 0; i < LAT; i++) begin
        tick(1);
        chk("R6 busy through dip", busy, 1'b1);
        chk("R6 no pulse in dip", go, 1'b0);
      end
      chk("R6 inhibit in dip", inh, 1'b1);
      tick(4);
      chk("R6 still busy", busy, 1'b1);
      recover("R6 restart");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule